// File: doc/BRIEF.md
# Doorbell Message Router

This block carries doorbell messages between the cores of a cluster whose size is set by a parameter. A core posts a send command that holds one 32-bit message word. The router decodes the kind of doorbell from the word's type field. It then raises the matching pending flag in every core the word addresses. The word addresses either every core, when its broadcast bit is set, or each core whose processor-ID input equals the word's tag.

Each core can also post a clear command with a message word of its own. A clear lowers the decoded pending flag in that core only. Each core also has two acknowledge inputs, one per doorbell kind. Message types that stand for guest doorbells, guest critical doorbells and guest machine checks decode to no doorbell. Send and clear both ignore them. Every pending flag is a register and drives an output directly.

Top module: `dbr_msg_router`

## Requirements
- R1: While `rst` is high at a clock edge, every flag in `db_pend` and `cdb_pend` is low after that edge.
- R2: A send whose type field (bits 31:27) holds 0 sets the `db_pend` flag of each addressed core after the next clock edge. It leaves `cdb_pend` untouched.
- R3: A send whose type field holds 1 sets the `cdb_pend` flag of each addressed core after the next clock edge. It leaves `db_pend` untouched.
- R4: Type values 2, 3 and 4 (the guest kinds) and every value from 5 to 31 change no flag, whether they arrive by send or by clear.
- R5: With bit 26 of a send word set, every core is addressed, whatever the tag holds.
- R6: With bit 26 clear, exactly the cores whose `core_pir` slice equals bits 13:0 are addressed. That may be several cores or none.
- R7: A clear posted on `clr_valid[i]` lowers the flag of core i that matches its type (0 normal, 1 critical). The other flag of core i and all flags of other cores are unchanged.
- R8: When a send sets a flag in the same cycle that a clear or an acknowledge lowers it, the flag is high after the edge.
- R9: A flag holds its value until a clear or a pulse on `ack_norm[i]` / `ack_crit[i]` lowers it. Each acknowledge lowers only its own kind in its own core.
- R10: Bits 25:14 of a send word play no part in addressing. The tag compare uses all 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_valid | input | 1 | Send command strobe |
| send_msg | input | 32 | Send message word |
| clr_valid | input | NUM_CORES | Per-core clear strobe |
| clr_msg | input | 32*NUM_CORES | Per-core clear message word, core i at bits 32i+31:32i |
| ack_norm | input | NUM_CORES | Per-core acknowledge of the normal doorbell |
| ack_crit | input | NUM_CORES | Per-core acknowledge of the critical doorbell |
| core_pir | input | 14*NUM_CORES | Per-core processor ID, core i at bits 14i+13:14i |
| db_pend | output | NUM_CORES | Normal doorbell pending per core |
| cdb_pend | output | NUM_CORES | Critical doorbell pending per core |

## Verification
The properties assume `core_pir` is stable while a send is in flight. They also assume `send_valid` and the clear and acknowledge strobes are sampled only once reset has been released. The hold and ignore properties require that no clear or acknowledge occurs in the same cycle. The bench therefore drives guest-type sends with all other strobes low, so the ignore check stays clean. It sets the processor IDs once, before reset ends, and it deliberately gives two cores the same ID. It changes every input only on the falling edge.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;
  localparam int MSG_W     = 32;
  localparam int TYPE_HI   = 31;
  localparam int TYPE_LO   = 27;
  localparam int TYPE_W    = TYPE_HI - TYPE_LO + 1;
  localparam int BCAST_BIT = 26;
  localparam int TAG_W     = 14;

  typedef enum logic [TYPE_W-1:0] {
    MT_NORM  = 5'd0,
    MT_CRIT  = 5'd1,
    MT_GNORM = 5'd2,
    MT_GCRIT = 5'd3,
    MT_GMCHK = 5'd4
  } msg_type_e;

  typedef struct packed {
    logic norm;
    logic crit;
  } db_kind_t;

  function automatic db_kind_t kind_of(input logic [TYPE_W-1:0] t);
    db_kind_t k;
    k = '0;
    case (t)
      MT_NORM: k.norm = 1'b1;
      MT_CRIT: k.crit = 1'b1;
      default: k = '0;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/dbr_type_dec.sv
`timescale 1ns/1ps
module dbr_type_dec
  import dbr_pkg::*;
(
  input  logic [TYPE_W-1:0] type_i,
  output db_kind_t          kind_o
);
  always_comb kind_o = kind_of(type_i);
endmodule

// File: rtl/dbr_target.sv
`timescale 1ns/1ps
module dbr_target
  import dbr_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                       bcast_i,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [NUM_CORES*TAG_W-1:0] pir_i,
  output logic [NUM_CORES-1:0]       hit_o
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_cmp
    assign hit_o[g] = bcast_i | (pir_i[g*TAG_W +: TAG_W] == tag_i);
  end
endmodule

// File: rtl/dbr_pend_cell.sv
`timescale 1ns/1ps
module dbr_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic drop_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)         pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (drop_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/dbr_msg_router.sv
`timescale 1ns/1ps
module dbr_msg_router
  import dbr_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       send_valid,
  input  logic [MSG_W-1:0]           send_msg,
  input  logic [NUM_CORES-1:0]       clr_valid,
  input  logic [NUM_CORES*MSG_W-1:0] clr_msg,
  input  logic [NUM_CORES-1:0]       ack_norm,
  input  logic [NUM_CORES-1:0]       ack_crit,
  input  logic [NUM_CORES*TAG_W-1:0] core_pir,
  output logic [NUM_CORES-1:0]       db_pend,
  output logic [NUM_CORES-1:0]       cdb_pend
);
  localparam int MID_LO = TAG_W;
  localparam int MID_HI = BCAST_BIT - 1;
  localparam int CLR_REST_W = TYPE_LO;

  db_kind_t               send_kind;
  logic [NUM_CORES-1:0]   hit;
  logic [NUM_CORES-1:0]   unused_clr_rest;
  logic                   unused_send_mid;

  assign unused_send_mid = ^send_msg[MID_HI:MID_LO];

  dbr_type_dec u_send_dec (
    .type_i (send_msg[TYPE_HI:TYPE_LO]),
    .kind_o (send_kind)
  );

  dbr_target #(.NUM_CORES(NUM_CORES)) u_target (
    .bcast_i (send_msg[BCAST_BIT]),
    .tag_i   (send_msg[TAG_W-1:0]),
    .pir_i   (core_pir),
    .hit_o   (hit)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    db_kind_t   clr_kind;
    logic [MSG_W-1:0] word;
    logic set_n, set_c, drop_n, drop_c;

    assign word = clr_msg[g*MSG_W +: MSG_W];
    assign unused_clr_rest[g] = ^word[CLR_REST_W-1:0];

    dbr_type_dec u_clr_dec (
      .type_i (word[TYPE_HI:TYPE_LO]),
      .kind_o (clr_kind)
    );

    assign set_n  = send_valid & send_kind.norm & hit[g];
    assign set_c  = send_valid & send_kind.crit & hit[g];
    assign drop_n = (clr_valid[g] & clr_kind.norm) | ack_norm[g];
    assign drop_c = (clr_valid[g] & clr_kind.crit) | ack_crit[g];

    dbr_pend_cell u_norm (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_n),
      .drop_i (drop_n),
      .pend_o (db_pend[g])
    );

    dbr_pend_cell u_crit (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_c),
      .drop_i (drop_c),
      .pend_o (cdb_pend[g])
    );
  end
endmodule

// File: rtl/dbr_msg_router_chk.sv
`timescale 1ns/1ps
module dbr_msg_router_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           send_valid,
  input logic [31:0]    send_msg,
  input logic [N-1:0]   clr_valid,
  input logic [N*32-1:0] clr_msg,
  input logic [N-1:0]   ack_norm,
  input logic [N-1:0]   ack_crit,
  input logic [N-1:0]   db_pend,
  input logic [N-1:0]   cdb_pend
);
  logic quiet;
  assign quiet = (clr_valid == '0) && (ack_norm == '0) && (ack_crit == '0);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (db_pend == '0) && (cdb_pend == '0)); // R1

  AST_BCAST_NORM: assert property (@(posedge clk) disable iff (rst)
    send_valid && send_msg[31:27] == 5'd0 && send_msg[26] |=> &db_pend); // R5

  AST_BCAST_CRIT: assert property (@(posedge clk) disable iff (rst)
    send_valid && send_msg[31:27] == 5'd1 && send_msg[26] |=> &cdb_pend); // R3

  AST_GUEST_IGNORED: assert property (@(posedge clk) disable iff (rst)
    send_valid && send_msg[31:27] >= 5'd2 && quiet
    |=> $stable(db_pend) && $stable(cdb_pend)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !send_valid && quiet |=> $stable(db_pend) && $stable(cdb_pend)); // R9

  for (genvar i = 0; i < N; i++) begin : g_core
    AST_CLEAR_LOCAL: assert property (@(posedge clk) disable iff (rst)
      !send_valid && clr_valid[i] && clr_msg[i*32+27 +: 5] == 5'd0
      |=> !db_pend[i]); // R7
    AST_ACK_CRIT: assert property (@(posedge clk) disable iff (rst)
      !send_valid && ack_crit[i] |=> !cdb_pend[i]); // R9
  end
endmodule

bind dbr_msg_router dbr_msg_router_chk #(.N(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .send_valid (send_valid),
  .send_msg   (send_msg),
  .clr_valid  (clr_valid),
  .clr_msg    (clr_msg),
  .ack_norm   (ack_norm),
  .ack_crit   (ack_crit),
  .db_pend    (db_pend),
  .cdb_pend   (cdb_pend)
);

// File: tb/dbr_msg_router_tb.sv
`timescale 1ns/1ps
module dbr_msg_router_tb;
  localparam int N = 4;

  typedef struct {
    logic [N-1:0] db;
    logic [N-1:0] cdb;
    string        req;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           send_valid = 1'b0;
  logic [31:0]    send_msg = '0;
  logic [N-1:0]   clr_valid = '0;
  logic [N*32-1:0] clr_msg = '0;
  logic [N-1:0]   ack_norm = '0;
  logic [N-1:0]   ack_crit = '0;
  logic [N*14-1:0] core_pir;
  logic [N-1:0]   db_pend, cdb_pend;

  logic [13:0]    pir [N] = '{14'd5, 14'd9, 14'd5, 14'h3FFF};
  logic [N-1:0]   m_db = '0, m_cdb = '0;
  exp_t           q[$];
  int             checks = 0, fails = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_pir
    assign core_pir[g*14 +: 14] = pir[g];
  end

  dbr_msg_router #(.NUM_CORES(N)) u_dut (
    .clk(clk), .rst(rst), .send_valid(send_valid), .send_msg(send_msg),
    .clr_valid(clr_valid), .clr_msg(clr_msg), .ack_norm(ack_norm),
    .ack_crit(ack_crit), .core_pir(core_pir), .db_pend(db_pend),
    .cdb_pend(cdb_pend)
  );

  function automatic logic [31:0] mk(input logic [4:0] t, input logic b,
                                     input logic [13:0] tag,
                                     input logic [11:0] mid = '0);
    return {t, b, mid, tag};
  endfunction

  task automatic drive(input logic sv, input logic [31:0] sm,
                       input logic [N-1:0] cv, input logic [N*32-1:0] cm,
                       input logic [N-1:0] an, input logic [N-1:0] ac,
                       input string req);
    exp_t e;
    @(negedge clk);
    send_valid = sv; send_msg = sm; clr_valid = cv; clr_msg = cm;
    ack_norm = an; ack_crit = ac;
    for (int i = 0; i < N; i++) begin
      logic hit, sn, sc, dn, dc;
      logic [4:0] ct;
      hit = sm[26] || (pir[i] == sm[13:0]);
      sn  = sv && sm[31:27] == 5'd0 && hit;
      sc  = sv && sm[31:27] == 5'd1 && hit;
      ct  = cm[i*32+27 +: 5];
      dn  = (cv[i] && ct == 5'd0) || an[i];
      dc  = (cv[i] && ct == 5'd1) || ac[i];
      m_db[i]  = sn | (m_db[i]  & ~dn);
      m_cdb[i] = sc | (m_cdb[i] & ~dc);
    end
    e.db = m_db; e.cdb = m_cdb; e.req = req;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input string req);
    drive(1'b0, '0, '0, '0, '0, '0, req);
  endtask

  function automatic logic [N*32-1:0] clr1(input int core, input logic [4:0] t);
    logic [N*32-1:0] v = '0;
    v[core*32+27 +: 5] = t;
    return v;
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (db_pend !== e.db || cdb_pend !== e.cdb) begin
          fails++;
          $display("FAIL %s: db=%b cdb=%b expected db=%b cdb=%b",
                   e.req, db_pend, cdb_pend, e.db, e.cdb);
        end
      end
    end
  end

  initial begin : watchdog
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (db_pend !== '0 || cdb_pend !== '0) begin
      fails++;
      $display("FAIL R1: db=%b cdb=%b expected 0000 0000", db_pend, cdb_pend);
    end
    rst = 1'b0;
    // R6 unicast normal to core 1
    drive(1, mk(5'd0, 0, 14'd9), '0, '0, '0, '0, "R2 R6 unicast normal");
    // R6 two cores share ID 5, critical
    drive(1, mk(5'd1, 0, 14'd5), '0, '0, '0, '0, "R3 R6 shared ID critical");
    // R6 tag matching no core
    drive(1, mk(5'd0, 0, 14'd7), '0, '0, '0, '0, "R6 no match");
    // R10 middle bits ignored
    drive(1, mk(5'd0, 0, 14'd5, 12'hABC), '0, '0, '0, '0, "R10 middle bits");
    // R10 full width compare
    drive(1, mk(5'd0, 0, 14'h1FFF), '0, '0, '0, '0, "R10 full tag width");
    // R5 broadcast critical
    drive(1, mk(5'd1, 1, 14'd1234), '0, '0, '0, '0, "R5 broadcast critical");
    // R4 guest and unused types by send
    drive(1, mk(5'd2, 1, 14'd5), '0, '0, '0, '0, "R4 guest normal send");
    drive(1, mk(5'd3, 1, 14'd5), '0, '0, '0, '0, "R4 guest critical send");
    drive(1, mk(5'd4, 1, 14'd9), '0, '0, '0, '0, "R4 guest mcheck send");
    drive(1, mk(5'd9, 1, 14'd9), '0, '0, '0, '0, "R4 unused type send");
    // R4 guest types by clear
    drive(0, '0, 4'b0001, clr1(0, 5'd3), '0, '0, "R4 guest clear");
    // R7 clear normal on core 1
    drive(0, '0, 4'b0010, clr1(1, 5'd0), '0, '0, "R7 local normal clear");
    // R9 ack critical on core 2
    drive(0, '0, '0, '0, '0, 4'b0100, "R9 critical ack");
    idle("R9 hold idle");
    idle("R9 hold idle 2");
    // R8 set beats clear and ack
    drive(1, mk(5'd0, 1, 14'd0), 4'b1000, clr1(3, 5'd0), 4'b0001, '0,
          "R8 set wins");
    // R7 simultaneous critical clears on cores 0 and 3
    drive(0, '0, 4'b1001, clr1(0, 5'd1) | clr1(3, 5'd1), '0, '0,
          "R7 two critical clears");
    // R9 ack normal on core 2
    drive(0, '0, '0, '0, 4'b0100, '0, "R9 normal ack");
    idle("R9 final hold");
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule